// File: doc/BRIEF.md
# Integrating Counter Noise Filter

This block cleans a serial receive line before protocol logic reads it. The raw line is asynchronous to the filter clock. It first passes through a synchronizer chain, and a sampling register then captures it on each rising clock edge. The sampled bit steers a saturating up/down counter that moves one step on each falling clock edge. The counter rises while the line is high and falls while it is low.

A clean output bit changes state only when the counter reaches full scale or zero. This gives hysteresis: a noise burst shorter than the full travel of the counter never reaches the output. The block also brings out the counter value and a single-cycle strobe that marks every change of the clean output.

Top module: `rxf_noise_filter`

## Requirements
- R1: While rst_n is low at a clock edge, the counter is loaded with 15, filt_out is 1 and edge_pulse is 0.
- R2: A level applied to line_in after rising edge k first moves the counter at the falling edge that follows rising edge k+3 (two synchronizer stages, then the sampling register).
- R3: The counter moves by exactly one per falling edge: up when the sampled bit is 1, down when it is 0.
- R4: With the sampled bit at 1, a counter at 15 stays at 15.
- R5: With the sampled bit at 0, a counter at 0 stays at 0.
- R6: filt_out becomes 1 at the first rising edge after the counter reaches 15.
- R7: filt_out becomes 0 at the first rising edge after the counter reaches 0.
- R8: Between the end points filt_out holds its value. A low burst of 14 clocks on a settled high line leaves filt_out at 1, and a 15-clock burst flips it.
- R9: edge_pulse is 1 for exactly the one clock cycle in which filt_out has just changed, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock; rising edge samples, falling edge counts |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Raw asynchronous receive line |
| filt_out | output | 1 | Filtered receive data |
| count_out | output | 4 | Current integrator value, for debug |
| edge_pulse | output | 1 | One-cycle strobe on each change of filt_out |

## Verification
A counter that drifts by a wrong amount, or that wraps instead of saturating, shows up on count_out at the next falling edge. It shows on filt_out as an output flip one or more cycles early or late. The bench therefore pins the exact cycle of each output flip after a steady level, 18 rising edges after the change. A wrong pipeline depth moves that flip by one cycle. A latch that follows the counter instead of holding shows up when a 14-clock burst changes filt_out, which a correct latch never does.

// File: rtl/rxf_pkg.sv
// Shared constants for the receive noise filter.
// Assumes: a single filter clock and a synchronous active-low reset.
package rxf_pkg;
    parameter int unsigned RXF_CNT_W       = 4;
    parameter int unsigned RXF_SYNC_STAGES = 2;
endpackage

// File: rtl/rxf_sync.sv
// Synchronizer chain followed by the rising-edge sampling register.
// Assumes: the line idles high, so every stage resets to 1.
module rxf_sync #(
    parameter int unsigned STAGES = rxf_pkg::RXF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic sample_o
);
    logic [STAGES-1:0] chain_q;
    logic              sample_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw asynchronous line.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= line_in;
                end
            end else begin : g_next
                // Later stages: pass the bit one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Sampling register: holds the bit that steers the next count step.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_q <= 1'b1;
        else        sample_q <= chain_q[STAGES-1];
    end

    assign sample_o = sample_q;
endmodule

// File: rtl/rxf_integ.sv
// Saturating up/down integrator that moves one step on each falling edge.
// Assumes: sample_i is stable around the falling edge (it changes on rising edges).
module rxf_integ #(
    parameter int unsigned CNT_W = rxf_pkg::RXF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_BOT = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: step toward the sampled level, clamped at both end points.
    always_comb begin
        cnt_d = cnt_q;
        if (sample_i) begin
            if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
        end else begin
            if (cnt_q != CNT_BOT) cnt_d = cnt_q - 1'b1;
        end
    end

    // Counter register: updated on the falling edge; reset loads full scale.
    always_ff @(negedge clk) begin
        if (!rst_n) cnt_q <= CNT_TOP;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/rxf_latch.sv
// Hysteresis latch: sets at full scale, clears at zero, holds otherwise.
// It also produces a one-cycle strobe on every change of its output.
// Assumes: count_i changes only on falling edges.
module rxf_latch #(
    parameter int unsigned CNT_W = rxf_pkg::RXF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    output logic             filt_o,
    output logic             pulse_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_BOT = '0;

    logic filt_q;
    logic filt_d;
    logic pulse_q;

    // Next latch value: decided only at an end point.
    always_comb begin
        filt_d = filt_q;
        if (count_i == CNT_TOP)      filt_d = 1'b1;
        else if (count_i == CNT_BOT) filt_d = 1'b0;
    end

    // Latch and strobe registers, on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q  <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            filt_q  <= filt_d;
            pulse_q <= (filt_d != filt_q);
        end
    end

    assign filt_o  = filt_q;
    assign pulse_o = pulse_q;
endmodule

// File: rtl/rxf_noise_filter.sv
// Top of the receive noise filter: synchronizer, integrator, hysteresis latch.
// Assumes: line_in is asynchronous; rst_n is synchronous to clk.
module rxf_noise_filter #(
    parameter int unsigned CNT_W       = rxf_pkg::RXF_CNT_W,
    parameter int unsigned SYNC_STAGES = rxf_pkg::RXF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic             filt_out,
    output logic [CNT_W-1:0] count_out,
    output logic             edge_pulse
);
    logic             sample;
    logic [CNT_W-1:0] count;

    rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .sample_o (sample)
    );

    rxf_integ #(.CNT_W(CNT_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .count_o  (count)
    );

    rxf_latch #(.CNT_W(CNT_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_i  (count),
        .filt_o   (filt_out),
        .pulse_o  (edge_pulse)
    );

    assign count_out = count;
endmodule

// File: rtl/rxf_noise_filter_chk.sv
// Port-level properties of the noise filter, bound to the top module.
module rxf_noise_filter_chk #(
    parameter int unsigned CNT_W = rxf_pkg::RXF_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             filt_out,
    input logic [CNT_W-1:0] count_out,
    input logic             edge_pulse
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_BOT = '0;

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_out == $past(count_out)) ||
        (count_out == $past(count_out) + 1'b1) ||
        (count_out == $past(count_out) - 1'b1));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_out) == CNT_TOP) |-> (count_out != CNT_BOT));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_out) == CNT_BOT) |-> (count_out != CNT_TOP));

    // R6
    set_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_out) |-> ($past(count_out) == CNT_TOP));

    // R7
    clear_at_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_out) |-> ($past(count_out) == CNT_BOT));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(count_out) != CNT_TOP) && ($past(count_out) != CNT_BOT)) |-> $stable(filt_out));

    // R9
    strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse == (filt_out != $past(filt_out)));
endmodule

bind rxf_noise_filter rxf_noise_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .filt_out   (filt_out),
    .count_out  (count_out),
    .edge_pulse (edge_pulse)
);

// File: tb/tb_rxf_noise_filter.sv
`timescale 1ns/1ps
module tb_rxf_noise_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b1;
    logic       filt_out;
    logic [3:0] count_out;
    logic       edge_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    rxf_noise_filter dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .filt_out(filt_out), .count_out(count_out), .edge_pulse(edge_pulse)
    );

    always #2 clk = ~clk;

    // Each row: line level, rising edges held, expected count, expected filt_out.
    localparam int VEC [9][4] = '{
        '{0, 10,  8, 1},
        '{1,  6,  8, 1},
        '{0, 20,  0, 0},
        '{1,  8,  5, 0},
        '{0,  5,  6, 0},
        '{1, 16, 15, 1},
        '{0,  4, 14, 1},
        '{1,  4, 12, 1},
        '{1,  6, 15, 1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int mincnt;
        bit sawlow;
        bit sawpulse;
        // R1: state held while reset is low
        repeat (4) step();
        chk("R1 count", count_out, 15);
        chk("R1 filt", filt_out, 1);
        chk("R1 pulse", edge_pulse, 0);
        rst_n = 1'b1;
        repeat (3) step();

        // Table walk: R3 stepping, R4/R5 clamps, R6/R7/R8 latch behaviour
        for (int i = 0; i < 9; i++) begin
            line_in = VEC[i][0][0];
            repeat (VEC[i][1]) step();
            chk($sformatf("R3 vec%0d count", i), count_out, VEC[i][2]);
            chk($sformatf("R8 vec%0d filt", i), filt_out, VEC[i][3]);
        end

        // R1: reset in the middle of activity
        line_in = 1'b0;
        repeat (6) step();
        rst_n = 1'b0;
        line_in = 1'b1;
        repeat (3) step();
        chk("R1 mid count", count_out, 15);
        chk("R1 mid filt", filt_out, 1);
        chk("R1 mid pulse", edge_pulse, 0);
        rst_n = 1'b1;
        repeat (5) step();
        chk("R1 after release", count_out, 15);

        // R2/R7/R9: exact timing of the falling flip
        line_in = 1'b0;
        step();
        step();
        chk("R2 no move yet", count_out, 15);
        step();
        chk("R2 first step", count_out, 15);
        step();
        chk("R2 first step seen", count_out, 14);
        repeat (13) step();
        chk("R7 step17 count", count_out, 1);
        chk("R7 step17 filt", filt_out, 1);
        step();
        chk("R7 step18 count", count_out, 0);
        chk("R7 step18 filt", filt_out, 0);
        chk("R9 fall pulse", edge_pulse, 1);
        step();
        chk("R9 fall pulse end", edge_pulse, 0);
        repeat (10) step();
        chk("R5 clamp", count_out, 0);

        // R6/R9/R4: exact timing of the rising flip
        line_in = 1'b1;
        repeat (17) step();
        chk("R6 step17 count", count_out, 14);
        chk("R6 step17 filt", filt_out, 0);
        step();
        chk("R6 step18 count", count_out, 15);
        chk("R6 step18 filt", filt_out, 1);
        chk("R9 rise pulse", edge_pulse, 1);
        step();
        chk("R9 rise pulse end", edge_pulse, 0);
        repeat (10) step();
        chk("R4 clamp", count_out, 15);

        // R8: a 14-clock burst never reaches the output
        mincnt = 15; sawlow = 0; sawpulse = 0;
        line_in = 1'b0;
        for (int k = 0; k < 34; k++) begin
            if (k == 14) line_in = 1'b1;
            step();
            if (count_out < mincnt) mincnt = count_out;
            if (!filt_out) sawlow = 1;
            if (edge_pulse) sawpulse = 1;
        end
        chk("R8 burst14 min count", mincnt, 1);
        chk("R8 burst14 filt held", sawlow, 0);
        chk("R9 burst14 no pulse", sawpulse, 0);

        // R8: a 15-clock burst flips the output
        mincnt = 15; sawlow = 0;
        line_in = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (k == 15) line_in = 1'b1;
            step();
            if (count_out < mincnt) mincnt = count_out;
            if (!filt_out) sawlow = 1;
        end
        chk("R8 burst15 min count", mincnt, 0);
        chk("R8 burst15 filt flipped", sawlow, 1);
        chk("R6 burst15 recovered", filt_out, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule